// File: doc/BRIEF.md
# Register-Mapped Serial Port with Status and Interrupt

This block is a full-duplex asynchronous serial port that software drives through a small 32-bit register window. A write to the transmit holding register starts an 8-bit frame with one start bit and one stop bit and no parity. The receiver hunts for a start bit, samples each bit near its middle and places the finished byte in a receive register with a ready flag. Bit timing comes from a divider register that holds the number of clock cycles per bit; the divider is split into sixteen oversampling ticks per bit.

Status flags (transmit-empty, receive-ready, overrun and two enable acknowledges) are read from one status register. Two interrupt enables gate the ready and empty flags onto a single interrupt line. A control bit disables overrun detection, and a write-one-to-clear register clears the overrun flag.

The transmitter steps through the states TX_IDLE, TX_START, TX_DATA and TX_STOP. TX_IDLE moves to TX_START on a load from the holding register. TX_START moves to TX_DATA after sixteen ticks. TX_DATA moves to TX_STOP after the eighth data bit. TX_STOP returns to TX_IDLE after sixteen ticks. The receiver steps through RX_IDLE, RX_HUNT, RX_DATA and RX_STOP. RX_IDLE moves to RX_HUNT on a falling line edge. RX_HUNT moves to RX_DATA when the line is still low at tick eight, and back to RX_IDLE when it is high. RX_DATA moves to RX_STOP after the eighth bit. RX_STOP returns to RX_IDLE at the middle of the stop bit, which raises the done pulse when the line is high. Either machine is forced to its idle state whenever it is not enabled.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset the status register (offset 0x1C) reads 0x00000080, with only transmit-empty (bit 7) set. The line output is high and the interrupt is low.
- R2: Only the low 9 bits of a write to the transmit holding register (offset 0x28) are kept. Writing 0xFFFFFFFF reads back 0x000001FF, and the write clears transmit-empty.
- R3: Status bit 21 reads as the transmitter enable (control bit 3), and status bit 22 reads as the receiver enable (control bit 2).
- R4: With the global enable (control bit 0) and the transmitter enable set, a pending holding value is moved into the shifter when the shifter is idle, and transmit-empty sets again. The frame is sent as a low start bit, 8 data bits LSB first and a high stop bit. Each bit lasts 16*(divider>>4) clocks, where the divider is at offset 0x0C. A divider write takes effect at the next frame.
- R5: With the global and receiver enables set, a frame on the receive line confirmed low at mid start bit is stored in the receive register (offset 0x24), and receive-ready (status bit 5) sets.
- R6: Reading the receive register clears receive-ready.
- R7: A frame that completes while receive-ready is set and overrun detection is on sets overrun (status bit 3) and keeps the older byte. Writing 1 to bit 3 of offset 0x20 clears overrun.
- R8: With the overrun-disable bit (offset 0x08, bit 12) set, overrun never sets and the newer byte replaces the older one.
- R9: The interrupt is (receive-ready AND control bit 5) OR (transmit-empty AND control bit 7).
- R10: While the global enable is 0 the line output stays high, holding writes are not sent, and incoming frames are ignored.
- R11: A holding-register write in the same cycle as a shifter load keeps transmit-empty clear. Both bytes are sent in write order.
- R12: A low pulse on the receive line that ends before mid start bit produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Combined interrupt request |

## Verification
The holding-register write and the shifter load can fall in the same cycle. The bench provokes this with two holding writes on back-to-back cycles while the shifter is idle, so the first value is loaded in exactly the cycle the second write lands. It then checks that transmit-empty reads 0 and that both bytes appear on the line in write order, which shows that the write takes priority over the flag set caused by the load.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_DATA, RX_STOP} rx_state_t;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_CTRL3 = 8'h08;
    localparam logic [7:0] OFS_DIV   = 8'h0C;
    localparam logic [7:0] OFS_STAT  = 8'h1C;
    localparam logic [7:0] OFS_CLR   = 8'h20;
    localparam logic [7:0] OFS_RXD   = 8'h24;
    localparam logic [7:0] OFS_TXD   = 8'h28;

    localparam int B_EN     = 0;
    localparam int B_RE     = 2;
    localparam int B_TE     = 3;
    localparam int B_RXIE   = 5;
    localparam int B_TXIE   = 7;
    localparam int B_OVRDIS = 12;

    localparam int S_ORE  = 3;
    localparam int S_RXNE = 5;
    localparam int S_TXE  = 7;
    localparam int S_TACK = 21;
    localparam int S_RACK = 22;

endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
    parameter int DIV_W    = 16,
    parameter int OSR_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    localparam int PW = DIV_W - OSR_LOG2;

    logic [PW-1:0] period_q;
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] period_new;
    logic          unused_frac;

    assign unused_frac = ^div_in[OSR_LOG2-1:0];
    assign period_new  = (div_in[DIV_W-1:OSR_LOG2] == '0) ? PW'(1) : div_in[DIV_W-1:OSR_LOG2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PW'(1);
            cnt_q    <= '0;
        end else if (restart) begin
            period_q <= period_new;
            cnt_q    <= '0;
        end else if (cnt_q == period_q - PW'(1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    assign tick = !restart && (cnt_q == period_q - PW'(1));

endmodule

// File: rtl/sp_tx.sv
module sp_tx import serial_port_pkg::*; #(
    parameter int CHAR_W   = 8,
    parameter int DIV_W    = 16,
    parameter int OSR_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic [DIV_W-1:0]  div,
    output logic              txd,
    output logic              idle
);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam int CNT_W = OSR_LOG2;
    localparam logic [CNT_W-1:0] LAST_TICK = {CNT_W{1'b1}};
    localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(CHAR_W - 1);

    tx_state_t         state_q, state_d;
    logic [CHAR_W-1:0] shift_q;
    logic [IDX_W-1:0]  bit_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic              tick;
    logic              bit_end;

    sp_baud #(.DIV_W(DIV_W), .OSR_LOG2(OSR_LOG2)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .div_in  (div),
        .tick    (tick)
    );

    assign bit_end = tick && (tcnt_q == LAST_TICK);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load)                         state_d = TX_START;
            TX_START: if (bit_end)                      state_d = TX_DATA;
            TX_DATA:  if (bit_end && bit_q == LAST_BIT) state_d = TX_STOP;
            TX_STOP:  if (bit_end)                      state_d = TX_IDLE;
        endcase
        if (!active) state_d = TX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_q   <= '0;
            tcnt_q  <= '0;
        end else if (load) begin
            shift_q <= load_data;
            bit_q   <= '0;
            tcnt_q  <= '0;
        end else if (tick) begin
            tcnt_q <= tcnt_q + CNT_W'(1);
            if (bit_end && state_q == TX_DATA) begin
                shift_q <= shift_q >> 1;
                bit_q   <= bit_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

    assign idle = (state_q == TX_IDLE);

endmodule

// File: rtl/sp_rx.sv
module sp_rx import serial_port_pkg::*; #(
    parameter int CHAR_W   = 8,
    parameter int DIV_W    = 16,
    parameter int OSR_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rxd,
    input  logic [DIV_W-1:0]  div,
    output logic              done,
    output logic [CHAR_W-1:0] data
);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam int CNT_W = OSR_LOG2;
    localparam logic [CNT_W-1:0] LAST_TICK = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'((1 << (OSR_LOG2 - 1)) - 1);
    localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(CHAR_W - 1);

    rx_state_t         state_q, state_d;
    logic              sync1_q, sync2_q, prev_q;
    logic [CHAR_W-1:0] shift_q;
    logic [IDX_W-1:0]  bit_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic              done_q;
    logic              tick;
    logic              fall;
    logic              restart;
    logic              mid_start;
    logic              bit_end;

    assign fall      = prev_q && !sync2_q;
    assign restart   = (state_q == RX_IDLE) && active && fall;
    assign mid_start = tick && (tcnt_q == MID_TICK);
    assign bit_end   = tick && (tcnt_q == LAST_TICK);

    sp_baud #(.DIV_W(DIV_W), .OSR_LOG2(OSR_LOG2)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_in  (div),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= rxd;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (restart)   state_d = RX_HUNT;
            RX_HUNT: if (mid_start) state_d = sync2_q ? RX_IDLE : RX_DATA;
            RX_DATA: if (bit_end && bit_q == LAST_BIT) state_d = RX_STOP;
            RX_STOP: if (bit_end)   state_d = RX_IDLE;
        endcase
        if (!active) state_d = RX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_q   <= '0;
            tcnt_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= active && (state_q == RX_STOP) && bit_end && sync2_q;
            if (restart) begin
                bit_q  <= '0;
                tcnt_q <= '0;
            end else if (tick) begin
                if (state_q == RX_HUNT && mid_start) tcnt_q <= '0;
                else                                  tcnt_q <= tcnt_q + CNT_W'(1);
                if (state_q == RX_DATA && bit_end) begin
                    shift_q <= {sync2_q, shift_q[CHAR_W-1:1]};
                    bit_q   <= bit_q + IDX_W'(1);
                end
            end
        end
    end

    assign done = done_q;
    assign data = shift_q;

endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl import serial_port_pkg::*; #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int DIV_W    = 16,
    parameter int CHAR_W   = 8,
    parameter int HOLD_W   = 9,
    parameter int OSR_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CTRL3 = ADDR_W'(OFS_CTRL3);
    localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFS_DIV);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(OFS_RXD);
    localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(OFS_TXD);

    logic              ctrl_en, ctrl_re, ctrl_te, ctrl_rxie, ctrl_txie;
    logic              ovr_dis;
    logic [DIV_W-1:0]  div_q;
    logic [HOLD_W-1:0] tdr_q;
    logic [CHAR_W-1:0] rdr_q;
    logic              rxne, txe, ore;

    logic              wr, rd;
    logic              tdr_wr, rdr_rd, clr_ore;
    logic              tx_active, rx_active;
    logic              tx_idle, tx_load;
    logic              rx_done;
    logic [CHAR_W-1:0] rx_data;
    logic              ovr_evt;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:DIV_W];

    assign wr      = bus_sel && bus_wr;
    assign rd      = bus_sel && !bus_wr;
    assign tdr_wr  = wr && (bus_addr == A_TXD);
    assign rdr_rd  = rd && (bus_addr == A_RXD);
    assign clr_ore = wr && (bus_addr == A_CLR) && bus_wdata[S_ORE];

    assign tx_active = ctrl_en && ctrl_te;
    assign rx_active = ctrl_en && ctrl_re;
    assign tx_load   = tx_active && tx_idle && !txe;
    assign ovr_evt   = rx_done && rxne && !ovr_dis && !rdr_rd;

    sp_tx #(.CHAR_W(CHAR_W), .DIV_W(DIV_W), .OSR_LOG2(OSR_LOG2)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (tx_active),
        .load      (tx_load),
        .load_data (tdr_q[CHAR_W-1:0]),
        .div       (div_q),
        .txd       (txd),
        .idle      (tx_idle)
    );

    sp_rx #(.CHAR_W(CHAR_W), .DIV_W(DIV_W), .OSR_LOG2(OSR_LOG2)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (rx_active),
        .rxd    (rxd),
        .div    (div_q),
        .done   (rx_done),
        .data   (rx_data)
    );

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_re   <= 1'b0;
            ctrl_te   <= 1'b0;
            ctrl_rxie <= 1'b0;
            ctrl_txie <= 1'b0;
            ovr_dis   <= 1'b0;
            div_q     <= '0;
            tdr_q     <= '0;
        end else if (wr) begin
            unique case (bus_addr)
                A_CTRL: begin
                    ctrl_en   <= bus_wdata[B_EN];
                    ctrl_re   <= bus_wdata[B_RE];
                    ctrl_te   <= bus_wdata[B_TE];
                    ctrl_rxie <= bus_wdata[B_RXIE];
                    ctrl_txie <= bus_wdata[B_TXIE];
                end
                A_CTRL3: ovr_dis <= bus_wdata[B_OVRDIS];
                A_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
                A_TXD:   tdr_q   <= bus_wdata[HOLD_W-1:0];
                default: ;
            endcase
        end
    end

    // Status flags: a write of the holding register beats the load; a finished frame beats a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe   <= 1'b1;
            rxne  <= 1'b0;
            ore   <= 1'b0;
            rdr_q <= '0;
        end else begin
            if (tdr_wr)       txe <= 1'b0;
            else if (tx_load) txe <= 1'b1;

            if (rx_done) begin
                if (!rxne || ovr_dis || rdr_rd) begin
                    rdr_q <= rx_data;
                    rxne  <= 1'b1;
                end
            end else if (rdr_rd) begin
                rxne <= 1'b0;
            end

            if (ovr_evt)      ore <= 1'b1;
            else if (clr_ore) ore <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]   = ctrl_en;
                bus_rdata[B_RE]   = ctrl_re;
                bus_rdata[B_TE]   = ctrl_te;
                bus_rdata[B_RXIE] = ctrl_rxie;
                bus_rdata[B_TXIE] = ctrl_txie;
            end
            A_CTRL3: bus_rdata[B_OVRDIS] = ovr_dis;
            A_DIV:   bus_rdata[DIV_W-1:0] = div_q;
            A_STAT: begin
                bus_rdata[S_ORE]  = ore;
                bus_rdata[S_RXNE] = rxne;
                bus_rdata[S_TXE]  = txe;
                bus_rdata[S_TACK] = ctrl_te;
                bus_rdata[S_RACK] = ctrl_re;
            end
            A_RXD:   bus_rdata[CHAR_W-1:0] = rdr_q;
            A_TXD:   bus_rdata[HOLD_W-1:0] = tdr_q;
            default: ;
        endcase
    end

    assign irq = (rxne && ctrl_rxie) || (txe && ctrl_txie);

endmodule

// File: rtl/sp_checker.sv
module sp_checker import serial_port_pkg::*; (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        txd,
    input logic        irq,
    input logic        ctrl_en,
    input logic        ctrl_te,
    input logic        ctrl_rxie,
    input logic        ctrl_txie,
    input logic        ovr_dis,
    input logic        tx_load,
    input logic        tdr_wr,
    input logic        rdr_rd,
    input logic        rx_done,
    input logic        txe,
    input logic        rxne,
    input logic        ore,
    input logic [7:0]  rdr_q
);

    assert_tdr_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_TXD) |-> (bus_rdata[31:9] == '0));

    assert_ack_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_STAT) |-> (bus_rdata[S_TACK] == ctrl_te));

    assert_txe_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tdr_wr) |=> txe);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdr_rd && !rx_done) |=> !rxne);

    assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rxne && !ovr_dis && !rdr_rd) |=> (ore && rdr_q == $past(rdr_q)));

    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_dis && !ore) |=> !ore);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rxie && !ctrl_txie) |-> !irq);

    assert_irq_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne && ctrl_rxie) |-> irq);

    assert_line_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> txd);

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tdr_wr |=> !txe);

endmodule

bind serial_port_ctrl sp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .txd       (txd),
    .irq       (irq),
    .ctrl_en   (ctrl_en),
    .ctrl_te   (ctrl_te),
    .ctrl_rxie (ctrl_rxie),
    .ctrl_txie (ctrl_txie),
    .ovr_dis   (ovr_dis),
    .tx_load   (tx_load),
    .tdr_wr    (tdr_wr),
    .rdr_rd    (rdr_rd),
    .rx_done   (rx_done),
    .txe       (txe),
    .rxne      (rxne),
    .ore       (ore),
    .rdr_q     (rdr_q)
);

// File: tb/sim_serial_port_ctrl.sv
module sim_serial_port_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        irq;

    int total = 0;
    int bad = 0;

    // bench model of control and flags
    bit m_te, m_re, m_ore, m_rxne, m_txe, m_rxie, m_txie;

    serial_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] exp_stat();
        return (32'(m_ore) << 3) | (32'(m_rxne) << 5) | (32'(m_txe) << 7) |
               (32'(m_te) << 21) | (32'(m_re) << 22);
    endfunction

    function automatic logic exp_irq();
        return (m_rxne && m_rxie) || (m_txe && m_txie);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_ctrl(input bit en);
        wr_reg(8'h00, 32'(en) | (32'(m_re) << 2) | (32'(m_te) << 3) |
                      (32'(m_rxie) << 5) | (32'(m_txie) << 7));
    endtask

    task automatic send_frame(input logic [7:0] b, input int dq);
        @(negedge clk); rxd = 1'b0;
        repeat (16*dq) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16*dq) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (16*dq + 4) @(negedge clk);
    endtask

    task automatic capture(input int dq, output logic [7:0] b, output bit ok);
        int waited = 0;
        ok = 1'b1; b = '0;
        while (txd === 1'b1 && waited < 4000) begin @(negedge clk); waited++; end
        if (waited >= 4000) begin ok = 1'b0; return; end
        repeat (8*dq) @(negedge clk);
        if (txd !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (16*dq) @(negedge clk);
            b[i] = txd;
        end
        repeat (16*dq) @(negedge clk);
        if (txd !== 1'b1) ok = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  b, b2, got;
        bit ok;
        int dq, lows;
        void'($urandom(32'h5EED));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_txe = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(8'h1C, r);
        chk("R1 status after reset", r, 32'h80);
        chk("R1 line idle", 32'(txd), 32'd1);
        chk("R1 irq low", 32'(irq), 32'd0);

        // R2 holding register masking, while disabled
        wr_reg(8'h28, 32'hFFFF_FFFF);
        m_txe = 1'b0;
        rd_reg(8'h28, r);
        chk("R2 holding readback", r, 32'h1FF);
        rd_reg(8'h1C, r);
        chk("R2 txe cleared by write", r, exp_stat());

        // R10 nothing sent or received while disabled
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R10 line held high", 32'(lows), 32'd0);
        m_te = 1'b1; m_re = 1'b1;
        // R3 acks follow enables even while the global enable is off
        set_ctrl(1'b0);
        rd_reg(8'h1C, r);
        chk("R3 acks set", r, exp_stat());
        send_frame(8'h5A, 1);
        rd_reg(8'h1C, r);
        chk("R10 frame ignored", r, exp_stat());
        m_te = 1'b0; m_re = 1'b0;
        set_ctrl(1'b0);
        rd_reg(8'h1C, r);
        chk("R3 acks clear", r, exp_stat());

        // R4 pending byte goes out once enabled
        wr_reg(8'h0C, 32'd32);
        m_te = 1'b1; m_re = 1'b1;
        set_ctrl(1'b1);
        capture(2, got, ok);
        chk("R4 frame shape", 32'(ok), 32'd1);
        chk("R4 pending byte sent", 32'(got), 32'hFF);
        m_txe = 1'b1;
        rd_reg(8'h1C, r);
        chk("R4 txe set after load", r, exp_stat());

        // R9 interrupt combinations
        m_txie = 1'b1; set_ctrl(1'b1); @(negedge clk);
        chk("R9 irq from txe", 32'(irq), 32'(exp_irq()));
        m_txie = 1'b0; m_rxie = 1'b1; set_ctrl(1'b1); @(negedge clk);
        chk("R9 irq masked", 32'(irq), 32'(exp_irq()));
        send_frame(8'hC3, 2);
        m_rxne = 1'b1;
        chk("R9 irq from rxne", 32'(irq), 32'(exp_irq()));
        rd_reg(8'h24, r);
        m_rxne = 1'b0;
        chk("R5 first byte", r, 32'hC3);
        @(negedge clk);
        chk("R9 irq after read", 32'(irq), 32'(exp_irq()));
        m_rxie = 1'b0; set_ctrl(1'b1);

        // random traffic on both directions with changing divider
        for (int n = 0; n < 16; n++) begin
            dq = 2 + int'($urandom_range(0, 1));
            b  = 8'($urandom());
            wr_reg(8'h0C, 32'(dq * 16));
            if ($urandom_range(0, 1) == 1) begin
                wr_reg(8'h28, 32'(b));
                capture(dq, got, ok);
                chk("R4 random frame ok", 32'(ok), 32'd1);
                chk("R4 random byte", 32'(got), 32'(b));
                rd_reg(8'h1C, r);
                chk("R4 txe back", r, exp_stat());
            end else begin
                send_frame(b, dq);
                m_rxne = 1'b1;
                rd_reg(8'h1C, r);
                chk("R5 ready set", r, exp_stat());
                rd_reg(8'h24, r);
                chk("R5 random byte", r, 32'(b));
                m_rxne = 1'b0;
                rd_reg(8'h1C, r);
                chk("R6 ready cleared by read", r, exp_stat());
            end
            repeat (40) @(negedge clk);
        end

        // R7 overrun
        wr_reg(8'h0C, 32'd32);
        b = 8'($urandom()); b2 = ~b;
        send_frame(b, 2);
        send_frame(b2, 2);
        m_rxne = 1'b1; m_ore = 1'b1;
        rd_reg(8'h1C, r);
        chk("R7 overrun flagged", r, exp_stat());
        wr_reg(8'h20, 32'h8);
        m_ore = 1'b0;
        rd_reg(8'h1C, r);
        chk("R7 overrun cleared", r, exp_stat());
        rd_reg(8'h24, r);
        m_rxne = 1'b0;
        chk("R7 older byte kept", r, 32'(b));

        // R8 overrun disabled
        wr_reg(8'h08, 32'h1000);
        b = 8'($urandom()); b2 = b ^ 8'h3C;
        send_frame(b, 2);
        send_frame(b2, 2);
        m_rxne = 1'b1;
        rd_reg(8'h1C, r);
        chk("R8 no overrun", r, exp_stat());
        rd_reg(8'h24, r);
        m_rxne = 1'b0;
        chk("R8 newer byte", r, 32'(b2));
        wr_reg(8'h08, 32'h0);

        // R12 short low glitch
        dq = 2;
        @(negedge clk); rxd = 1'b0;
        repeat (int'($urandom_range(2, 8))) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        rd_reg(8'h1C, r);
        chk("R12 glitch ignored", r, exp_stat());
        send_frame(8'h81, dq);
        rd_reg(8'h24, r);
        chk("R12 next frame fine", r, 32'h81);
        m_rxne = 1'b0;

        // R11 holding write in the load cycle
        b = 8'($urandom()); b2 = 8'($urandom());
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'(b);
        @(negedge clk);
        bus_wdata = 32'(b2);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        m_txe = 1'b0;
        rd_reg(8'h1C, r);
        chk("R11 txe stays clear", r, exp_stat());
        capture(dq, got, ok);
        chk("R11 first byte", 32'(got), 32'(b));
        capture(dq, got, ok);
        chk("R11 second byte", 32'(got), 32'(b2));
        chk("R11 second frame ok", 32'(ok), 32'd1);
        m_txe = 1'b1;
        rd_reg(8'h1C, r);
        chk("R11 txe set after drain", r, exp_stat());

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule